// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a host bus and the program/erase engine of a parallel NOR flash. The host issues bus write cycles carrying an address and a data word. The block reads the command code from the low byte of the data and follows the one-, two- and three-cycle command sequences. It also decides which source a host read returns: the array, the status byte, the identification signature or the query table.

When a sequence completes, the block gives the program/erase controller a one-cycle start strobe. With it go an operation code and the operands it latched. The block also sends suspend and resume strobes. The controller answers with a one-cycle done pulse. The block keeps a status byte: a ready flag, suspend flags and sticky error flags.

While an operation is suspended, only a restricted set of commands is accepted, and the rest are dropped silently. During an erase suspend, a nested program, lock-class or protection program operation may run. When it ends, the block returns to the suspended erase.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, rd_sel is 0 (array), status is 80h, and no controller strobe is high.
- R2: A single write with low byte FFh, 70h, 90h or 98h sets rd_sel to 0, 1, 2 or 3 respectively, one cycle after the write. Unrecognised first-cycle codes, and D0h/B0h while idle, change nothing.
- R3: Code 20h followed by a write with low byte D0h starts operation 0 (erase), with ctl_addr taken from the second cycle. Any other confirm byte sets status bit 5, returns rd_sel to 0 and starts nothing.
- R4: Code 40h or 10h followed by an address/data write starts operation 1 (program), with both values latched.
- R5: Code 30h, then two address/data writes, starts operation 2 (double-word) on the third write. This happens only if the two addresses differ in bit 0 alone. Otherwise status bit 4 is set and nothing starts.
- R6: Code 60h followed by a write with low byte 01h, D0h or 2Fh starts operation 3 (lock), 4 (unlock) or 5 (lock-down) on that block address. Any other byte sets status bit 5.
- R7: Code C0h followed by an address/data write starts operation 6 (protection program).
- R8: With every start or resume, rd_sel becomes 1 (status) and status bit 7 (ready) goes low. Bit 7 returns high on ctl_done. Only one of the strobes is high in any cycle.
- R9: Code 50h clears status bits 1, 3, 4 and 5. Starting a new operation leaves these bits unchanged.
- R10: Code B0h while busy pulses ctl_suspend and sets ready. It also sets status bit 6 for an erase or status bit 2 for any other operation. B0h during a protection program is ignored.
- R11: Code D0h while suspended pulses ctl_resume with the suspended operation's code, and clears bits 6 and 2.
- R12: While a non-erase operation is suspended, only the read codes and resume are accepted. Every other write leaves strobes, status and rd_sel unchanged.
- R13: While an erase is suspended, program (40h/10h), 60h-class and C0h sequences are also accepted. A nested operation keeps bit 6 set, and its ctl_done returns the block to the suspended erase with ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | AW | Bus write address |
| wr_data | input | DW | Bus write data, command code in bits 7:0 |
| ctl_done | input | 1 | Controller finished the running operation |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature, 3 query |
| status | output | 8 | Status byte |
| ctl_start | output | 1 | Start pulse to controller |
| ctl_suspend | output | 1 | Suspend pulse to controller |
| ctl_resume | output | 1 | Resume pulse to controller |
| ctl_op | output | 3 | Operation code for the controller |
| ctl_addr | output | AW | First latched address |
| ctl_data | output | DW | First latched data |
| ctl_addr2 | output | AW | Second latched address (double-word) |
| ctl_data2 | output | DW | Second latched data (double-word) |

## Verification
The hardest state to reach is a nested operation inside an erase suspend. To get there, the stimulus starts an erase, suspends it, runs a program to completion and then resumes the erase. It checks at each step that bit 6 survives and that the resume carries the erase code. Sweeps cover all 256 first-cycle codes, all 256 lock-class confirm bytes and all 256 address pairs in a 4-bit window for the double-word check. Directed sequences cover the sticky error bits across a later operation.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_RDARR, K_RDSTAT, K_RDSIG, K_RDQRY, K_CLR, K_SUSP, K_RES,
    K_ERASE, K_PROG, K_DWORD, K_LOCK, K_PROT
  } cmd_kind_t;

  localparam logic [2:0] OP_ERASE  = 3'd0;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_DWORD  = 3'd2;
  localparam logic [2:0] OP_LOCK   = 3'd3;
  localparam logic [2:0] OP_UNLOCK = 3'd4;
  localparam logic [2:0] OP_LDOWN  = 3'd5;
  localparam logic [2:0] OP_PROT   = 3'd6;
  localparam logic [2:0] OP_BAD    = 3'd7;

  localparam logic [1:0] RD_ARRAY  = 2'd0;
  localparam logic [1:0] RD_STATUS = 2'd1;
  localparam logic [1:0] RD_SIG    = 2'd2;
  localparam logic [1:0] RD_QUERY  = 2'd3;

  function automatic cmd_kind_t classify(input logic [7:0] c);
    case (c)
      8'hFF:        return K_RDARR;
      8'h70:        return K_RDSTAT;
      8'h90:        return K_RDSIG;
      8'h98:        return K_RDQRY;
      8'h50:        return K_CLR;
      8'hB0:        return K_SUSP;
      8'hD0:        return K_RES;
      8'h20:        return K_ERASE;
      8'h40, 8'h10: return K_PROG;
      8'h30:        return K_DWORD;
      8'h60:        return K_LOCK;
      8'hC0:        return K_PROT;
      default:      return K_NONE;
    endcase
  endfunction

  // commands accepted while an operation is paused
  function automatic logic susp_legal(input cmd_kind_t k, input logic erase_paused);
    case (k)
      K_RES, K_RDARR, K_RDSTAT, K_RDSIG, K_RDQRY: return 1'b1;
      K_PROG, K_LOCK, K_PROT:                     return erase_paused;
      default:                                    return 1'b0;
    endcase
  endfunction

  // second byte of a 60h sequence -> operation, OP_BAD when unknown
  function automatic logic [2:0] lock_op(input logic [7:0] c);
    case (c)
      8'h01:   return OP_LOCK;
      8'hD0:   return OP_UNLOCK;
      8'h2F:   return OP_LDOWN;
      default: return OP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
(
  input  logic [7:0] code,
  input  logic       in_susp,
  input  logic       erase_paused,
  output cmd_kind_t  kind,
  output logic       legal
);
  always_comb begin
    kind  = classify(code);
    legal = in_susp ? susp_legal(kind, erase_paused) : 1'b1;
  end

  always_comb begin
    if (in_susp && !erase_paused && (code == 8'h40))
      assert_prog_blocked_R12: assert (!legal);
    if (in_susp && (code == 8'h20))
      assert_erase_blocked_R13: assert (!legal);
  end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_seq,
  input  logic       set_pair,
  input  logic       clr,
  input  logic       ready,
  input  logic       esusp,
  input  logic       psusp,
  output logic [7:0] status
);
  logic err_seq_q, err_pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_seq_q  <= 1'b0;
      err_pair_q <= 1'b0;
    end else if (clr) begin
      err_seq_q  <= 1'b0;
      err_pair_q <= 1'b0;
    end else begin
      if (set_seq)  err_seq_q  <= 1'b1;
      if (set_pair) err_pair_q <= 1'b1;
    end
  end

  assign status = {ready, esusp, err_seq_q, err_pair_q, 1'b0, psusp, 1'b0, 1'b0};

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status[5:3] == 3'b000 && status[1] == 1'b0));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clr) |=> status[5]);
  assert_seq_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_seq |=> status[5]);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcmd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ctl_done,
  output logic [1:0]    rd_sel,
  output logic [7:0]    status,
  output logic          ctl_start,
  output logic          ctl_suspend,
  output logic          ctl_resume,
  output logic [2:0]    ctl_op,
  output logic [AW-1:0] ctl_addr,
  output logic [DW-1:0] ctl_data,
  output logic [AW-1:0] ctl_addr2,
  output logic [DW-1:0] ctl_data2
);
  localparam logic [AW-1:0] LSB1 = AW'(1);

  typedef enum logic [2:0] {S_READY, S_SET, S_DW, S_BUSY, S_SUSP} state_t;

  function automatic logic pair_ok(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a ^ b) == LSB1;
  endfunction

  state_t        st_q, st_n;
  cmd_kind_t     setup_q, setup_n, kind;
  logic          legal;
  logic          from_susp_q, from_susp_n;
  logic          nest_q, nest_n;
  logic          epause_q, epause_n;
  logic [2:0]    run_op_q, run_op_n, op_n;
  logic [1:0]    rd_n;
  logic [AW-1:0] a1_q, a1_n, oa_n, oa2_n;
  logic [DW-1:0] d1_q, d1_n, od_n, od2_n;
  logic [7:0]    code;
  logic          susp_active, ready;

  // named internal events
  logic ev_start, ev_seq_err, ev_pair_err, ev_clr, ev_susp, ev_res;

  assign code        = wr_data[7:0];
  assign susp_active = (st_q == S_SUSP) || nest_q ||
                       (((st_q == S_SET) || (st_q == S_DW)) && from_susp_q);
  assign ready       = (st_q != S_BUSY);

  fcmd_decode u_dec (
    .code(code), .in_susp(st_q == S_SUSP), .erase_paused(epause_q),
    .kind(kind), .legal(legal)
  );

  fcmd_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_seq(ev_seq_err), .set_pair(ev_pair_err),
    .clr(ev_clr), .ready(ready), .esusp(susp_active && epause_q),
    .psusp(susp_active && !epause_q), .status(status)
  );

  always_comb begin
    st_n = st_q;  setup_n = setup_q;  from_susp_n = from_susp_q;
    nest_n = nest_q;  epause_n = epause_q;  run_op_n = run_op_q;
    op_n = ctl_op;  rd_n = rd_sel;
    a1_n = a1_q;  d1_n = d1_q;
    oa_n = ctl_addr;  od_n = ctl_data;  oa2_n = ctl_addr2;  od2_n = ctl_data2;
    ev_start = 1'b0;  ev_seq_err = 1'b0;  ev_pair_err = 1'b0;
    ev_clr = 1'b0;  ev_susp = 1'b0;  ev_res = 1'b0;
    case (st_q)
      S_READY, S_SUSP: if (wr_en && legal) begin
        case (kind)
          K_RDARR:  rd_n = RD_ARRAY;
          K_RDSTAT: rd_n = RD_STATUS;
          K_RDSIG:  rd_n = RD_SIG;
          K_RDQRY:  rd_n = RD_QUERY;
          K_CLR:    ev_clr = 1'b1;
          K_RES: if (st_q == S_SUSP) begin
            ev_res = 1'b1;  st_n = S_BUSY;  rd_n = RD_STATUS;  op_n = run_op_q;
          end
          K_ERASE, K_PROG, K_DWORD, K_LOCK, K_PROT: begin
            setup_n = kind;  st_n = S_SET;  from_susp_n = (st_q == S_SUSP);
          end
          default: ;
        endcase
      end
      S_SET: if (wr_en) begin
        case (setup_q)
          K_ERASE: if (code == 8'hD0) begin
            ev_start = 1'b1;  op_n = OP_ERASE;
          end else ev_seq_err = 1'b1;
          K_PROG:  begin ev_start = 1'b1;  op_n = OP_PROG; end
          K_PROT:  begin ev_start = 1'b1;  op_n = OP_PROT; end
          K_LOCK: if (lock_op(code) != OP_BAD) begin
            ev_start = 1'b1;  op_n = lock_op(code);
          end else ev_seq_err = 1'b1;
          K_DWORD: begin a1_n = wr_addr;  d1_n = wr_data;  st_n = S_DW; end
          default: ev_seq_err = 1'b1;
        endcase
        if (ev_start) begin oa_n = wr_addr;  od_n = wr_data; end
      end
      S_DW: if (wr_en) begin
        if (pair_ok(a1_q, wr_addr)) begin
          ev_start = 1'b1;  op_n = OP_DWORD;
          oa_n = a1_q;  od_n = d1_q;  oa2_n = wr_addr;  od2_n = wr_data;
        end else ev_pair_err = 1'b1;
      end
      S_BUSY: begin
        if (ctl_done) begin
          st_n = nest_q ? S_SUSP : S_READY;
          nest_n = 1'b0;
        end else if (wr_en && kind == K_SUSP && !nest_q && run_op_q != OP_PROT) begin
          ev_susp = 1'b1;  st_n = S_SUSP;  rd_n = RD_STATUS;
          epause_n = (run_op_q == OP_ERASE);  op_n = run_op_q;
        end
      end
      default: st_n = S_READY;
    endcase
    if (ev_start) begin
      st_n = S_BUSY;  rd_n = RD_STATUS;  nest_n = from_susp_q;
      if (!from_susp_q) run_op_n = op_n;
    end
    if (ev_seq_err || ev_pair_err) begin
      rd_n = RD_ARRAY;
      st_n = from_susp_q ? S_SUSP : S_READY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_READY;  setup_q <= K_NONE;  from_susp_q <= 1'b0;
      nest_q <= 1'b0;  epause_q <= 1'b0;  run_op_q <= OP_ERASE;
      rd_sel <= RD_ARRAY;  ctl_op <= OP_ERASE;
      a1_q <= '0;  d1_q <= '0;
      ctl_addr <= '0;  ctl_data <= '0;  ctl_addr2 <= '0;  ctl_data2 <= '0;
      ctl_start <= 1'b0;  ctl_suspend <= 1'b0;  ctl_resume <= 1'b0;
    end else begin
      st_q <= st_n;  setup_q <= setup_n;  from_susp_q <= from_susp_n;
      nest_q <= nest_n;  epause_q <= epause_n;  run_op_q <= run_op_n;
      rd_sel <= rd_n;  ctl_op <= op_n;
      a1_q <= a1_n;  d1_q <= d1_n;
      ctl_addr <= oa_n;  ctl_data <= od_n;  ctl_addr2 <= oa2_n;  ctl_data2 <= od2_n;
      ctl_start <= ev_start;  ctl_suspend <= ev_susp;  ctl_resume <= ev_res;
    end
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_start, ctl_suspend, ctl_resume}));
  assert_start_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start |-> (rd_sel == RD_STATUS && !status[7]));
  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_start && ctl_op == OP_DWORD) |-> ((ctl_addr2 ^ ctl_addr) == LSB1));
  assert_no_prot_susp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_suspend |-> (ctl_op != OP_PROT && status[7]));
  assert_resume_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_resume |-> ($past(status[6] | status[2]) && !status[7]));
endmodule

// File: tb/test_flash_cmd_fsm.sv
module test_flash_cmd_fsm;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ctl_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] rd_sel;
  logic [7:0] status;
  logic ctl_start, ctl_suspend, ctl_resume;
  logic [2:0] ctl_op;
  logic [AW-1:0] ctl_addr, ctl_addr2;
  logic [DW-1:0] ctl_data, ctl_data2;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_fsm #(.AW(AW), .DW(DW)) i_flash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_done(ctl_done), .rd_sel(rd_sel), .status(status), .ctl_start(ctl_start),
    .ctl_suspend(ctl_suspend), .ctl_resume(ctl_resume), .ctl_op(ctl_op),
    .ctl_addr(ctl_addr), .ctl_data(ctl_data), .ctl_addr2(ctl_addr2), .ctl_data2(ctl_data2)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done();
    ctl_done = 1'b1;
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  // strobes packed {start,suspend,resume}
  function automatic logic [2:0] strobes();
    return {ctl_start, ctl_suspend, ctl_resume};
  endfunction

  function automatic logic [1:0] exp_rd(input logic [7:0] c);
    case (c)
      8'hFF: return 2'd0;  8'h70: return 2'd1;
      8'h90: return 2'd2;  8'h98: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] exp_lock(input logic [7:0] c); // {valid,op}
    if (c == 8'h01) return 4'b1011;
    if (c == 8'hD0) return 4'b1100;
    if (c == 8'h2F) return 4'b1101;
    return 4'b0000;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 rd_sel", rd_sel, 0);
    check("R1 status", status, 8'h80);
    check("R1 strobes", strobes(), 0);

    // R2 sweep of every first-cycle code from reset
    for (int c = 0; c < 256; c++) begin
      do_reset();
      wr(8'h00, 16'(c));
      check("R2 rd_sel", rd_sel, exp_rd(8'(c)));
      check("R2 status", status, 8'h80);
      check("R2 strobes", strobes(), 0);
    end

    // R6 sweep of every confirm byte after 60h
    for (int d = 0; d < 256; d++) begin
      logic [3:0] e;
      e = exp_lock(8'(d));
      do_reset();
      wr(8'h00, 16'h0060);
      wr(8'h5A, 16'(d));
      if (e[3]) begin
        check("R6 start", {ctl_start, ctl_op, ctl_addr}, {1'b1, e[2:0], 8'h5A});
        check("R8 busy", status, 8'h00);
        done();
        check("R8 done ready", status, 8'h80);
      end else begin
        check("R6 reject", {ctl_start, status, rd_sel}, {1'b0, 8'hA0, 2'd0});
      end
    end

    // R5 sweep of double-word address pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        wr(8'h00, 16'h0030);
        wr(8'(a), 16'h1234);
        check("R5 no early start", ctl_start, 0);
        wr(8'(b), 16'h5678);
        if ((a ^ b) == 1) begin
          check("R5 start", {ctl_start, ctl_op}, {1'b1, 3'd2});
          check("R5 operands", {ctl_addr, ctl_data, ctl_addr2, ctl_data2},
                {8'(a), 16'h1234, 8'(b), 16'h5678});
          done();
        end else begin
          check("R5 pair error", {ctl_start, status}, {1'b0, 8'h90});
        end
      end
    end

    // R3 erase
    do_reset();
    wr(8'h00, 16'h0020); wr(8'h33, 16'h00D0);
    check("R3 erase start", {ctl_start, ctl_op, ctl_addr}, {1'b1, 3'd0, 8'h33});
    check("R8 rd status", rd_sel, 1);
    done();
    wr(8'h00, 16'h0020); wr(8'h33, 16'h00FF);
    check("R3 bad confirm", {ctl_start, status, rd_sel}, {1'b0, 8'hA0, 2'd0});

    // R9 sticky across a program, then clear
    wr(8'h00, 16'h0040); wr(8'h44, 16'hBEEF);
    check("R4 prog 40", {ctl_start, ctl_op, ctl_addr, ctl_data}, {1'b1, 3'd1, 8'h44, 16'hBEEF});
    check("R9 sticky busy", status, 8'h20);
    done();
    check("R9 sticky after", status, 8'hA0);
    wr(8'h00, 16'h0050);
    check("R9 cleared", status, 8'h80);
    wr(8'h00, 16'h0010); wr(8'h45, 16'hCAFE);
    check("R4 prog 10", {ctl_start, ctl_op, ctl_data}, {1'b1, 3'd1, 16'hCAFE});
    done();

    // R7 protection program, and R10 no suspend of it
    wr(8'h00, 16'h00C0); wr(8'h02, 16'hFFF0);
    check("R7 prot start", {ctl_start, ctl_op, ctl_addr}, {1'b1, 3'd6, 8'h02});
    wr(8'h00, 16'h00B0);
    check("R10 prot unsuspendable", {strobes(), status}, {3'b000, 8'h00});
    done();

    // R10/R11 erase suspend and resume
    wr(8'h00, 16'h0020); wr(8'h60, 16'h00D0);
    wr(8'h00, 16'h00B0);
    check("R10 erase suspend", {strobes(), status, rd_sel}, {3'b010, 8'hC0, 2'd1});
    wr(8'h00, 16'h0020);
    check("R13 erase ignored", {strobes(), status, rd_sel}, {3'b000, 8'hC0, 2'd1});
    // R13 nested program inside erase suspend
    wr(8'h00, 16'h0040); wr(8'h77, 16'hABCD);
    check("R13 nested start", {ctl_start, ctl_op, ctl_addr}, {1'b1, 3'd1, 8'h77});
    check("R13 nested busy", status, 8'h40);
    wr(8'h00, 16'h00B0);
    check("R13 nested no suspend", strobes(), 0);
    done();
    check("R13 back to suspend", status, 8'hC0);
    wr(8'h00, 16'h00D0);
    check("R11 resume", {strobes(), ctl_op, status, rd_sel}, {3'b001, 3'd0, 8'h00, 2'd1});
    done();
    check("R11 finished", status, 8'h80);

    // R12 program suspend filtering
    wr(8'h00, 16'h0040); wr(8'h11, 16'h0F0F);
    wr(8'h00, 16'h00B0);
    check("R10 prog suspend", {strobes(), status}, {3'b010, 8'h84});
    wr(8'h00, 16'h0040);
    check("R12 prog ignored", {strobes(), status, rd_sel}, {3'b000, 8'h84, 2'd1});
    wr(8'h00, 16'h0060); wr(8'h00, 16'h0001);
    check("R12 lock ignored", {strobes(), status, rd_sel}, {3'b000, 8'h84, 2'd1});
    wr(8'h00, 16'h0090);
    check("R12 read sig ok", rd_sel, 2);
    wr(8'h00, 16'h00D0);
    check("R11 prog resume", {strobes(), ctl_op, status}, {3'b001, 3'd1, 8'h00});
    done();
    check("R11 prog finished", status, 8'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule